// File: doc/BRIEF.md
# Burst Selector for a Row-Buffer-Aware Memory Scheduler

This block decides which waiting DRAM request goes out next. It looks at a queue of request descriptors, each with a valid bit, a rank, a bank, a row and an age, and at status from elsewhere in the controller. That status is made up of four things: the open row and column-ready time of every bank, which ranks are able to take commands, the rank used by the last burst, and whether the data bus is turning between reads and writes. From these it picks one queue slot.

Requests that hit an already open row and can start right away are served first. Hits that cannot start right away come next, then requests to the banks that will be ready soonest, and finally any eligible request. A read/write turnaround adds a fixed extra delay to every bank's ready time. The same turnaround removes the preference for staying on the previous rank. Within a priority tier the entry that has waited longest wins.

The decision logic is combinational. It is captured in output registers, so the choice for the inputs present at a clock edge can be read for the whole following cycle. Queue storage, command generation and the timing counters live in neighbouring blocks.

Top module: `burst_selector`

## Requirements
- R1: While reset is asserted, pickValid, pickIdx, pickSeamless and earlyMask are all zero.
- R2: The outputs after a rising clock edge are a function of the inputs sampled at that edge only. They stay unchanged until the next edge.
- R3: pickValid is 1 exactly when at least one entry is valid and its rank has its rankAvail bit set. Otherwise pickIdx, pickSeamless and earlyMask are all zero.
- R4: An entry that is invalid, or whose rank is unavailable, is never chosen and never contributes a bit to earlyMask.
- R5: Outside a turnaround (dirSwitch=0), a seamless row hit (open row equal to the entry's row, and effective ready time not later than nowTime) on rank prevRank beats every other entry, even older ones.
- R6: During a turnaround (dirSwitch=1), switchDelay is added to every bank's ready time. A seamless hit on any available rank is then in the top tier.
- R7: If the top tier is empty, any eligible row hit, ready or not, is chosen ahead of non-hits.
- R8: earlyMask has bit rank*NBANK+bank set for every bank that has an eligible entry and whose effective ready time equals the minimum over such banks. With no hits, the oldest entry whose bank bit is set in earlyMask is chosen.
- R9: Within the winning tier the entry with the larger age wins. On equal age the lower slot index wins.
- R10: pickSeamless is 1 exactly when the chosen entry is a row hit whose effective ready time is not later than nowTime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entValid | input | DEPTH | Per-slot valid bit |
| entRank | input | DEPTH x RANK_W | Rank of each slot |
| entBank | input | DEPTH x BANK_W | Bank within rank of each slot |
| entRow | input | DEPTH x ROW_W | Row of each slot |
| entAge | input | DEPTH x AGE_W | Waiting time of each slot, larger is older |
| bankOpen | input | NRANK*NBANK | A row is open in the bank |
| bankOpenRow | input | NRANK*NBANK x ROW_W | Open row of each bank |
| bankReadyAt | input | NRANK*NBANK x TIME_W | Earliest column time of each bank |
| nowTime | input | TIME_W | Current time in the same units |
| rankAvail | input | NRANK | Rank may accept commands |
| prevRank | input | RANK_W | Rank used by the previous burst |
| dirSwitch | input | 1 | Next burst turns the bus around |
| switchDelay | input | TIME_W | Extra column delay during a turnaround |
| pickValid | output | 1 | Some entry targets an available rank |
| pickIdx | output | IDX_W | Chosen queue slot |
| pickSeamless | output | 1 | Chosen burst can start without a bus gap |
| earlyMask | output | NRANK*NBANK | Banks with the earliest effective ready time |

## Verification
The checker checks on every cycle the properties that hold regardless of the priority order. pickValid must agree with the set of valid entries on available ranks, and the chosen slot must be one of them. earlyMask must be non-empty exactly when a choice exists and must hold no bit for an unavailable rank. The seamless flag may only be raised together with a choice, and reset must clear everything. The tier ordering cannot be seen from those properties alone, so it is shown only by the bench's scenarios. Those scenarios cover the rank preference and its removal during a turnaround, the turnaround delay, hits that are not ready, ties in the earliest-bank mask, and age ties.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int NUM_TIERS = 4;

  // Strobes from control to datapath: which tier to draw from, and
  // whether any choice exists at all.
  typedef struct packed {
    logic [NUM_TIERS-1:0] tierOneHot;
    logic                 anyPick;
  } bsel_strobe_t;
endpackage

// File: rtl/bsel_control.sv
module bsel_control
  import bsel_pkg::*;
(
  input  logic [NUM_TIERS-1:0] tierNonEmpty,
  output bsel_strobe_t         strobe
);
  logic [NUM_TIERS-1:0] taken;

  // Lowest non-empty tier wins; tier 0 is the highest priority.
  always_comb begin
    strobe.tierOneHot = '0;
    taken = '0;
    for (int t = 0; t < NUM_TIERS; t++) begin
      if (t == 0) begin
        strobe.tierOneHot[t] = tierNonEmpty[t];
        taken[t]             = tierNonEmpty[t];
      end else begin
        strobe.tierOneHot[t] = tierNonEmpty[t] & ~taken[t-1];
        taken[t]             = tierNonEmpty[t] | taken[t-1];
      end
    end
    strobe.anyPick = taken[NUM_TIERS-1];
  end
endmodule

// File: rtl/bsel_datapath.sv
module bsel_datapath
  import bsel_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 2,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int AGE_W  = 8,
  parameter int TIME_W = 16,
  localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int TOT    = NRANK * NBANK,
  localparam int BID_W  = (TOT > 1) ? $clog2(TOT) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DEPTH-1:0]                  entValid,
  input  logic [DEPTH-1:0][RANK_W-1:0]      entRank,
  input  logic [DEPTH-1:0][BANK_W-1:0]      entBank,
  input  logic [DEPTH-1:0][ROW_W-1:0]       entRow,
  input  logic [DEPTH-1:0][AGE_W-1:0]       entAge,
  input  logic [TOT-1:0]                    bankOpen,
  input  logic [TOT-1:0][ROW_W-1:0]         bankOpenRow,
  input  logic [TOT-1:0][TIME_W-1:0]        bankReadyAt,
  input  logic [TIME_W-1:0]                 nowTime,
  input  logic [NRANK-1:0]                  rankAvail,
  input  logic [RANK_W-1:0]                 prevRank,
  input  logic                              dirSwitch,
  input  logic [TIME_W-1:0]                 switchDelay,
  input  bsel_strobe_t                      strobe,
  output logic [NUM_TIERS-1:0]              tierNonEmpty,
  output logic                              pickValid,
  output logic [IDX_W-1:0]                  pickIdx,
  output logic                              pickSeamless,
  output logic [TOT-1:0]                    earlyMask
);
  logic [TOT-1:0][TIME_W:0]     effReady;
  logic [DEPTH-1:0][BID_W-1:0]  bid;
  logic [DEPTH-1:0]             eligible, isHit, isReady, onPref, inEarly;
  logic [TOT-1:0]               bankWanted, earlyC;
  logic [TIME_W:0]              minReady;
  logic                         minSeen;
  logic [NUM_TIERS-1:0][DEPTH-1:0] tierCand;
  logic [DEPTH-1:0]             finalCand;
  logic [IDX_W-1:0]             bestIdx;
  logic [AGE_W-1:0]             bestAge;
  logic                         bestFound;

  // Effective column-ready time per bank, widened to avoid wrap.
  genvar gb;
  generate
    for (gb = 0; gb < TOT; gb++) begin : g_bank
      assign effReady[gb] = {1'b0, bankReadyAt[gb]} +
                            (dirSwitch ? {1'b0, switchDelay} : '0);
    end
  endgenerate

  // Per-entry classification.
  genvar ge;
  generate
    for (ge = 0; ge < DEPTH; ge++) begin : g_ent
      assign bid[ge]      = BID_W'(entRank[ge]) * BID_W'(NBANK) + BID_W'(entBank[ge]);
      assign eligible[ge] = entValid[ge] & rankAvail[entRank[ge]];
      assign isHit[ge]    = bankOpen[bid[ge]] & (bankOpenRow[bid[ge]] == entRow[ge]);
      assign isReady[ge]  = effReady[bid[ge]] <= {1'b0, nowTime};
      assign onPref[ge]   = dirSwitch | (entRank[ge] == prevRank);
      assign inEarly[ge]  = earlyC[bid[ge]];
    end
  endgenerate

  // Banks that have eligible work, and the earliest of them.
  always_comb begin
    bankWanted = '0;
    for (int i = 0; i < DEPTH; i++)
      if (eligible[i]) bankWanted[bid[i]] = 1'b1;
    minReady = '0;
    minSeen  = 1'b0;
    for (int b = 0; b < TOT; b++)
      if (bankWanted[b] && (!minSeen || effReady[b] < minReady)) begin
        minReady = effReady[b];
        minSeen  = 1'b1;
      end
    for (int b = 0; b < TOT; b++)
      earlyC[b] = bankWanted[b] && (effReady[b] == minReady);
  end

  // Priority tiers, 0 highest.
  assign tierCand[0] = eligible & isHit & isReady & onPref;
  assign tierCand[1] = eligible & isHit;
  assign tierCand[2] = eligible & inEarly;
  assign tierCand[3] = eligible;

  genvar gt;
  generate
    for (gt = 0; gt < NUM_TIERS; gt++) begin : g_tier
      assign tierNonEmpty[gt] = |tierCand[gt];
    end
  endgenerate

  // Oldest entry of the tier chosen by control; ties go to lower index.
  always_comb begin
    finalCand = '0;
    for (int t = 0; t < NUM_TIERS; t++)
      if (strobe.tierOneHot[t]) finalCand = finalCand | tierCand[t];
    bestIdx   = '0;
    bestAge   = '0;
    bestFound = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (finalCand[i] && (!bestFound || entAge[i] > bestAge)) begin
        bestIdx   = IDX_W'(i);
        bestAge   = entAge[i];
        bestFound = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pickValid    <= 1'b0;
      pickIdx      <= '0;
      pickSeamless <= 1'b0;
      earlyMask    <= '0;
    end else begin
      pickValid    <= strobe.anyPick;
      pickIdx      <= strobe.anyPick ? bestIdx : '0;
      pickSeamless <= strobe.anyPick & isHit[bestIdx] & isReady[bestIdx];
      earlyMask    <= strobe.anyPick ? earlyC : '0;
    end
  end
endmodule

// File: rtl/burst_selector.sv
module burst_selector
  import bsel_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 2,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int AGE_W  = 8,
  parameter int TIME_W = 16,
  localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int TOT    = NRANK * NBANK,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              entValid,
  input  logic [DEPTH-1:0][RANK_W-1:0]  entRank,
  input  logic [DEPTH-1:0][BANK_W-1:0]  entBank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   entRow,
  input  logic [DEPTH-1:0][AGE_W-1:0]   entAge,
  input  logic [TOT-1:0]                bankOpen,
  input  logic [TOT-1:0][ROW_W-1:0]     bankOpenRow,
  input  logic [TOT-1:0][TIME_W-1:0]    bankReadyAt,
  input  logic [TIME_W-1:0]             nowTime,
  input  logic [NRANK-1:0]              rankAvail,
  input  logic [RANK_W-1:0]             prevRank,
  input  logic                          dirSwitch,
  input  logic [TIME_W-1:0]             switchDelay,
  output logic                          pickValid,
  output logic [IDX_W-1:0]              pickIdx,
  output logic                          pickSeamless,
  output logic [TOT-1:0]                earlyMask
);
  bsel_strobe_t         strobe;
  logic [NUM_TIERS-1:0] tierNonEmpty;

  bsel_control u_ctrl (
    .tierNonEmpty (tierNonEmpty),
    .strobe       (strobe)
  );

  bsel_datapath #(
    .DEPTH(DEPTH), .NRANK(NRANK), .NBANK(NBANK),
    .ROW_W(ROW_W), .AGE_W(AGE_W), .TIME_W(TIME_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .entValid(entValid), .entRank(entRank), .entBank(entBank),
    .entRow(entRow), .entAge(entAge),
    .bankOpen(bankOpen), .bankOpenRow(bankOpenRow), .bankReadyAt(bankReadyAt),
    .nowTime(nowTime), .rankAvail(rankAvail), .prevRank(prevRank),
    .dirSwitch(dirSwitch), .switchDelay(switchDelay),
    .strobe(strobe), .tierNonEmpty(tierNonEmpty),
    .pickValid(pickValid), .pickIdx(pickIdx),
    .pickSeamless(pickSeamless), .earlyMask(earlyMask)
  );
endmodule

// File: rtl/burst_selector_chk.sv
module burst_selector_chk #(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 2,
  parameter int NBANK  = 8,
  localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int TOT    = NRANK * NBANK,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [DEPTH-1:0]             entValid,
  input logic [DEPTH-1:0][RANK_W-1:0] entRank,
  input logic [NRANK-1:0]             rankAvail,
  input logic                         pickValid,
  input logic [IDX_W-1:0]             pickIdx,
  input logic                         pickSeamless,
  input logic [TOT-1:0]               earlyMask
);
  logic [DEPTH-1:0]             lastValid;
  logic [DEPTH-1:0][RANK_W-1:0] lastRank;
  logic [NRANK-1:0]             lastAvail;
  logic                         anyElig;
  logic [TOT-1:0]               availBanks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastValid <= '0;
      lastRank  <= '0;
      lastAvail <= '0;
    end else begin
      lastValid <= entValid;
      lastRank  <= entRank;
      lastAvail <= rankAvail;
    end
  end

  always_comb begin
    anyElig = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (lastValid[i] && lastAvail[lastRank[i]]) anyElig = 1'b1;
    for (int b = 0; b < TOT; b++)
      availBanks[b] = lastAvail[b / NBANK];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!pickValid && pickIdx == '0 && !pickSeamless && earlyMask == '0));

  assert_valid_iff_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pickValid == anyElig);

  assert_idle_outputs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pickValid |-> (pickIdx == '0 && !pickSeamless && earlyMask == '0));

  assert_pick_is_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pickValid |-> (lastValid[pickIdx] && lastAvail[lastRank[pickIdx]]));

  assert_mask_on_avail_ranks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pickValid |-> (earlyMask != '0 && (earlyMask & ~availBanks) == '0));

  assert_seamless_needs_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pickSeamless |-> pickValid);
endmodule

bind burst_selector burst_selector_chk #(
  .DEPTH(DEPTH), .NRANK(NRANK), .NBANK(NBANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .entValid(entValid), .entRank(entRank),
  .rankAvail(rankAvail), .pickValid(pickValid), .pickIdx(pickIdx),
  .pickSeamless(pickSeamless), .earlyMask(earlyMask)
);

// File: tb/burst_selector_bench.sv
`timescale 1ns/1ps
module burst_selector_bench;
  localparam int DEPTH = 16, NRANK = 2, NBANK = 8, ROW_W = 14, AGE_W = 8, TIME_W = 16;
  localparam int TOT = NRANK * NBANK;

  typedef struct packed {
    logic [1:0]  avail;
    logic        prv;
    logic        sw;
    logic [15:0] now;
    logic        expValid;
    logic [3:0]  expIdx;
    logic        expSeam;
    logic [15:0] expMask;
  } vec_t;

  // Shared population: e0 r0b3 row1 age40, e1 r0b1 row5 age10 (hit),
  // e2 r1b2 row7 age20 (hit), e3 r1b4 row9 age30. Ready: b1=10, b3=20,
  // b10=12, b12=15, switch delay 4.
  localparam vec_t TBL [8] = '{
    '{2'b11, 1'b0, 1'b0, 16'd12, 1'b1, 4'd1, 1'b1, 16'h0002}, // R5 R10 preferred rank0 seamless
    '{2'b11, 1'b1, 1'b0, 16'd12, 1'b1, 4'd2, 1'b1, 16'h0002}, // R5 preferred rank1 seamless
    '{2'b11, 1'b1, 1'b0, 16'd11, 1'b1, 4'd2, 1'b0, 16'h0002}, // R7 R9 hits not top tier, older hit
    '{2'b11, 1'b0, 1'b1, 16'd12, 1'b1, 4'd2, 1'b0, 16'h0002}, // R6 delay makes none ready
    '{2'b11, 1'b0, 1'b1, 16'd20, 1'b1, 4'd2, 1'b1, 16'h0002}, // R6 any rank top tier
    '{2'b01, 1'b1, 1'b0, 16'd12, 1'b1, 4'd1, 1'b1, 16'h0002}, // R4 R7 seamless off-rank hit
    '{2'b10, 1'b0, 1'b0, 16'd5,  1'b1, 4'd2, 1'b0, 16'h0400}, // R4 R8 mask of rank1 only
    '{2'b00, 1'b0, 1'b0, 16'd12, 1'b0, 4'd0, 1'b0, 16'h0000}  // R3 nothing available
  };

  logic clk = 0, rst_n = 0;
  logic [DEPTH-1:0]             entValid;
  logic [DEPTH-1:0][0:0]        entRank;
  logic [DEPTH-1:0][2:0]        entBank;
  logic [DEPTH-1:0][ROW_W-1:0]  entRow;
  logic [DEPTH-1:0][AGE_W-1:0]  entAge;
  logic [TOT-1:0]               bankOpen;
  logic [TOT-1:0][ROW_W-1:0]    bankOpenRow;
  logic [TOT-1:0][TIME_W-1:0]   bankReadyAt;
  logic [TIME_W-1:0]            nowTime, switchDelay;
  logic [NRANK-1:0]             rankAvail;
  logic [0:0]                   prevRank;
  logic                         dirSwitch;
  logic                         pickValid, pickSeamless;
  logic [3:0]                   pickIdx;
  logic [TOT-1:0]               earlyMask;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_selector u_burst_selector (
    .clk(clk), .rst_n(rst_n), .entValid(entValid), .entRank(entRank),
    .entBank(entBank), .entRow(entRow), .entAge(entAge), .bankOpen(bankOpen),
    .bankOpenRow(bankOpenRow), .bankReadyAt(bankReadyAt), .nowTime(nowTime),
    .rankAvail(rankAvail), .prevRank(prevRank), .dirSwitch(dirSwitch),
    .switchDelay(switchDelay), .pickValid(pickValid), .pickIdx(pickIdx),
    .pickSeamless(pickSeamless), .earlyMask(earlyMask)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic setEnt(input int i, input logic r, input logic [2:0] b,
                        input logic [ROW_W-1:0] row, input logic [AGE_W-1:0] age);
    entValid[i] = 1'b1; entRank[i] = r; entBank[i] = b; entRow[i] = row; entAge[i] = age;
  endtask

  task automatic population();
    entValid = '0; entRank = '0; entBank = '0; entRow = '0; entAge = '0;
    bankOpen = '0; bankOpenRow = '0;
    for (int b = 0; b < TOT; b++) bankReadyAt[b] = 16'd50;
    bankOpen[1] = 1'b1;  bankOpenRow[1] = 14'd5;  bankReadyAt[1] = 16'd10;
    bankOpen[10] = 1'b1; bankOpenRow[10] = 14'd7; bankReadyAt[10] = 16'd12;
    bankReadyAt[3] = 16'd20; bankReadyAt[12] = 16'd15;
    setEnt(0, 1'b0, 3'd3, 14'd1, 8'd40);
    setEnt(1, 1'b0, 3'd1, 14'd5, 8'd10);
    setEnt(2, 1'b1, 3'd2, 14'd7, 8'd20);
    setEnt(3, 1'b1, 3'd4, 14'd9, 8'd30);
    switchDelay = 16'd4;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic v, input logic [3:0] idx,
                      input logic s, input logic [15:0] m);
    chk({tag, " valid"}, 32'(pickValid), 32'(v));
    chk({tag, " idx"}, 32'(pickIdx), 32'(idx));
    chk({tag, " seamless"}, 32'(pickSeamless), 32'(s));
    chk({tag, " mask"}, 32'(earlyMask), 32'(m));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    population();
    rankAvail = 2'b11; prevRank = 1'b0; dirSwitch = 1'b0; nowTime = 16'd12;
    repeat (3) @(negedge clk);
    outs("R1 reset", 1'b0, 4'd0, 1'b0, 16'h0000);
    rst_n = 1'b1;

    // Table walk
    for (int k = 0; k < 8; k++) begin
      rankAvail = TBL[k].avail; prevRank = TBL[k].prv;
      dirSwitch = TBL[k].sw; nowTime = TBL[k].now;
      step();
      outs($sformatf("table row %0d (R3 R4 R5 R6 R7 R8 R10)", k),
           TBL[k].expValid, TBL[k].expIdx, TBL[k].expSeam, TBL[k].expMask);
    end

    // R2: output holds until the next edge, then follows
    rankAvail = 2'b11; prevRank = 1'b0; dirSwitch = 1'b0; nowTime = 16'd12;
    step();
    rankAvail = 2'b00;
    #1;
    chk("R2 held before edge", 32'(pickValid), 32'd1);
    step();
    chk("R2 follows after edge", 32'(pickValid), 32'd0);

    // R8: no hits, tie in the earliest-bank mask
    rankAvail = 2'b11; nowTime = 16'd0; bankOpen = '0; bankReadyAt[12] = 16'd10;
    step();
    outs("R8 tie oldest in mask", 1'b1, 4'd3, 1'b0, 16'h1002);
    bankReadyAt[12] = 16'd15;
    step();
    outs("R8 early bank beats older", 1'b1, 4'd1, 1'b0, 16'h0002);

    // R9 age tie and R4 invalid / unavailable entries
    population();
    rankAvail = 2'b11; prevRank = 1'b0; dirSwitch = 1'b0; nowTime = 16'd12;
    setEnt(5, 1'b0, 3'd1, 14'd5, 8'd50);
    setEnt(9, 1'b0, 3'd1, 14'd5, 8'd50);
    setEnt(6, 1'b0, 3'd1, 14'd5, 8'd200); entValid[6] = 1'b0;
    setEnt(7, 1'b1, 3'd2, 14'd7, 8'd250);
    step();
    outs("R9 equal age lower index", 1'b1, 4'd5, 1'b1, 16'h0002);
    rankAvail = 2'b01; prevRank = 1'b1;
    step();
    outs("R4 unavailable rank skipped", 1'b1, 4'd5, 1'b1, 16'h0002);
    rankAvail = 2'b11;
    step();
    outs("R5 rank1 oldest seamless", 1'b1, 4'd7, 1'b1, 16'h0002);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule